// File: doc/BRIEF.md
# Exception Priority Arbiter

This block takes the state of every exception vector (enable, pending, active and an 8-bit programmed priority) and decides what the processor should do next. It finds the highest-priority pending vector, computes the group priority of the most urgent active handler, and combines that with the processor's masking state to produce two decisions. The first is a preemption request that ignores the processor masks. The second is a "can take now" flag that respects them.

Vector 0 is never used. Vectors 1, 2 and 3 are the reset, non-maskable and hard-fault exceptions, and each has a fixed negative priority. External interrupt line n is vector 16+n. Priorities are carried as 10-bit two's-complement values, so the negative fixed levels and the idle level 256 (one above any programmable byte) compare correctly. Arbitration is combinational across the whole vector array. All results are registered once, so they appear one clock edge after the inputs that produced them.

Top module: `exc_prio_arb`

## Requirements
- R1: Only a vector with both its enable bit and its pending bit set is a candidate. The candidate with the numerically lowest priority is reported as the pending vector number and pending priority. The programmed priority of vector v is the byte at bits [8v+7:8v] of the priority bus.
- R2: When two candidates have equal priority, the one with the lower vector number is reported.
- R3: Vector 0 is never reported, even when it is enabled, pending and programmed to priority 0.
- R4: Vectors 1, 2 and 3 use the fixed priorities -3, -2 and -1 (10-bit 0x3FD, 0x3FE, 0x3FF), whatever their programmed bytes hold.
- R5: When no candidate exists, the pending vector is 0 and the pending priority is 256 (0x100).
- R6: The active priority output is the lowest priority among active vectors, ANDed in 10-bit two's complement with a group mask of all ones shifted left by (grouping field + 1). With no vector active it is 256.
- R7: The preemption output is high exactly when the pending priority is strictly less than the active priority output. The fault mask, interrupt mask and base threshold have no effect on it.
- R8: The running level is -1 if the fault mask is set. Otherwise it is 0 if the interrupt mask is set, otherwise the base threshold term, otherwise 256. The execution priority is the minimum of the running level and the active priority output. The can-take flag is high exactly when the execution priority is strictly greater than the pending priority.
- R9: A base threshold of zero has no effect. A nonzero threshold is zero-extended and ANDed with the group mask before it takes part in R8.
- R10: Every output appears one clock edge after its inputs. While reset is asserted, the outputs read vector 0, pending priority 256, active priority 256, and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_en_i | input | NVEC | Per-vector enable bits |
| vec_pend_i | input | NVEC | Per-vector pending bits |
| vec_act_i | input | NVEC | Per-vector active bits |
| prio_cfg_i | input | 8*NVEC | Programmed priority bytes, vector v at [8v+7:8v] |
| grp_sel_i | input | 3 | Priority grouping split point |
| fault_mask_i | input | 1 | Processor fault mask |
| irq_mask_i | input | 1 | Processor global interrupt mask |
| base_thr_i | input | 8 | Base-priority threshold, zero disables |
| pend_vec_o | output | clog2(NVEC) | Highest-priority pending vector number |
| pend_prio_o | output | 10 | Its priority, two's complement |
| act_prio_o | output | 10 | Masked active priority, two's complement |
| preempt_o | output | 1 | Preemption request |
| can_take_o | output | 1 | Pending vector may be taken now |

## Verification
All five results pass through a single register stage, so every output is due on the first rising edge after its inputs change. The driver changes the inputs on a falling edge and queues the expected values. The monitor compares them 1 time unit after the next rising edge, which is exactly one register stage later, and never samples at an edge. The reset values are read directly while reset is held, before any entry is queued.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int PRIO_W     = 8;
    localparam int EXT_W      = 10;
    localparam int FIRST_EXT  = 16;

    typedef logic signed [EXT_W-1:0] prio_t;

    localparam prio_t IDLE_PRIO  = 10'sd256;
    localparam prio_t RESET_PRIO = -10'sd3;
    localparam prio_t NMI_PRIO   = -10'sd2;
    localparam prio_t HARD_PRIO  = -10'sd1;

    function automatic prio_t group_mask(input logic [2:0] grp);
        prio_t m;
        m = '1;
        return prio_t'(m << (int'(grp) + 1));
    endfunction
endpackage

// File: rtl/arb_prio_map.sv
module arb_prio_map
    import arb_pkg::*;
#(
    parameter int NVEC = 48
) (
    input  logic [NVEC*PRIO_W-1:0] prio_cfg_i,
    output prio_t [NVEC-1:0]       eff_prio_o
);
    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        if (v >= 1 && v <= 3) begin : g_fixed
            logic unused_cfg;
            assign unused_cfg = ^prio_cfg_i[v*PRIO_W +: PRIO_W];
            assign eff_prio_o[v] = (v == 1) ? RESET_PRIO :
                                   (v == 2) ? NMI_PRIO : HARD_PRIO;
        end else begin : g_prog
            assign eff_prio_o[v] = prio_t'({2'b00, prio_cfg_i[v*PRIO_W +: PRIO_W]});
        end
    end
endmodule

// File: rtl/arb_pend_pick.sv
module arb_pend_pick
    import arb_pkg::*;
#(
    parameter int NVEC = 48,
    localparam int VW  = $clog2(NVEC)
) (
    input  logic [NVEC-1:0]  vec_en_i,
    input  logic [NVEC-1:0]  vec_pend_i,
    input  prio_t [NVEC-1:0] eff_prio_i,
    output logic [VW-1:0]    best_vec_o,
    output prio_t            best_prio_o
);
    logic unused_v0;
    assign unused_v0 = vec_en_i[0] ^ vec_pend_i[0] ^ (^eff_prio_i[0]);

    always_comb begin
        best_vec_o  = '0;
        best_prio_o = IDLE_PRIO;
        for (int v = 1; v < NVEC; v++) begin
            if (vec_en_i[v] && vec_pend_i[v] &&
                ($signed(eff_prio_i[v]) < $signed(best_prio_o))) begin
                best_prio_o = eff_prio_i[v];
                best_vec_o  = VW'(v);
            end
        end
    end
endmodule

// File: rtl/arb_act_min.sv
module arb_act_min
    import arb_pkg::*;
#(
    parameter int NVEC = 48
) (
    input  logic [NVEC-1:0]  vec_act_i,
    input  prio_t [NVEC-1:0] eff_prio_i,
    output prio_t            min_prio_o
);
    logic unused_v0;
    assign unused_v0 = vec_act_i[0] ^ (^eff_prio_i[0]);

    always_comb begin
        min_prio_o = IDLE_PRIO;
        for (int v = 1; v < NVEC; v++) begin
            if (vec_act_i[v] && ($signed(eff_prio_i[v]) < $signed(min_prio_o))) begin
                min_prio_o = eff_prio_i[v];
            end
        end
    end
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
    import arb_pkg::*;
#(
    parameter int  NUM_EXT = 32,
    localparam int NVEC    = FIRST_EXT + NUM_EXT,
    localparam int VW      = $clog2(NVEC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NVEC-1:0]        vec_en_i,
    input  logic [NVEC-1:0]        vec_pend_i,
    input  logic [NVEC-1:0]        vec_act_i,
    input  logic [NVEC*PRIO_W-1:0] prio_cfg_i,
    input  logic [2:0]             grp_sel_i,
    input  logic                   fault_mask_i,
    input  logic                   irq_mask_i,
    input  logic [PRIO_W-1:0]      base_thr_i,
    output logic [VW-1:0]          pend_vec_o,
    output logic [EXT_W-1:0]       pend_prio_o,
    output logic [EXT_W-1:0]       act_prio_o,
    output logic                   preempt_o,
    output logic                   can_take_o
);
    typedef struct packed {
        logic [VW-1:0] vec;
        prio_t         pend_prio;
        prio_t         act_prio;
        logic          preempt;
        logic          can_take;
    } arb_state_t;

    prio_t [NVEC-1:0] eff_prio;
    logic [VW-1:0]    best_vec;
    prio_t            best_prio;
    prio_t            act_min;

    arb_prio_map #(.NVEC(NVEC)) u_map (
        .prio_cfg_i (prio_cfg_i),
        .eff_prio_o (eff_prio)
    );

    arb_pend_pick #(.NVEC(NVEC)) u_pick (
        .vec_en_i    (vec_en_i),
        .vec_pend_i  (vec_pend_i),
        .eff_prio_i  (eff_prio),
        .best_vec_o  (best_vec),
        .best_prio_o (best_prio)
    );

    arb_act_min #(.NVEC(NVEC)) u_act (
        .vec_act_i  (vec_act_i),
        .eff_prio_i (eff_prio),
        .min_prio_o (act_min)
    );

    arb_state_t state_d, state_q;
    prio_t      grp_mask;
    prio_t      act_masked;
    prio_t      run_lvl;
    prio_t      exec_prio;

    always_comb begin
        grp_mask   = group_mask(grp_sel_i);
        act_masked = act_min & grp_mask;

        if (fault_mask_i) begin
            run_lvl = -10'sd1;
        end else if (irq_mask_i) begin
            run_lvl = 10'sd0;
        end else if (base_thr_i != '0) begin
            run_lvl = prio_t'({2'b00, base_thr_i}) & grp_mask;
        end else begin
            run_lvl = IDLE_PRIO;
        end

        exec_prio = ($signed(run_lvl) < $signed(act_masked)) ? run_lvl : act_masked;

        state_d.vec       = best_vec;
        state_d.pend_prio = best_prio;
        state_d.act_prio  = act_masked;
        state_d.preempt   = $signed(best_prio) < $signed(act_masked);
        state_d.can_take  = $signed(exec_prio) > $signed(best_prio);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.vec       <= '0;
            state_q.pend_prio <= IDLE_PRIO;
            state_q.act_prio  <= IDLE_PRIO;
            state_q.preempt   <= 1'b0;
            state_q.can_take  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_vec_o  = state_q.vec;
    assign pend_prio_o = state_q.pend_prio;
    assign act_prio_o  = state_q.act_prio;
    assign preempt_o   = state_q.preempt;
    assign can_take_o  = state_q.can_take;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter int  NUM_EXT = 32,
    localparam int NVEC    = 16 + NUM_EXT,
    localparam int VW      = $clog2(NVEC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NVEC-1:0] vec_en_i,
    input logic [NVEC-1:0] vec_pend_i,
    input logic [NVEC-1:0] vec_act_i,
    input logic            fault_mask_i,
    input logic [VW-1:0]   pend_vec_o,
    input logic [9:0]      pend_prio_o,
    input logic [9:0]      act_prio_o,
    input logic            preempt_o,
    input logic            can_take_o
);
    // R1
    no_cand_zero_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(vec_en_i & vec_pend_i)) |=> (pend_vec_o == '0));

    // R5
    idle_pend_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec_o == '0) |-> (pend_prio_o == 10'h100));

    // R6
    no_active_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|vec_act_i) |=> (act_prio_o == 10'h100));

    // R7
    no_preempt_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec_o == '0) |-> !preempt_o);

    // R8
    take_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        can_take_o |-> (pend_vec_o != '0));

    // R8
    fault_mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_mask_i |=> (!can_take_o || ($signed(pend_prio_o) < -10'sd1)));
endmodule

bind exc_prio_arb arb_chk #(.NUM_EXT(NUM_EXT)) u_arb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vec_en_i     (vec_en_i),
    .vec_pend_i   (vec_pend_i),
    .vec_act_i    (vec_act_i),
    .fault_mask_i (fault_mask_i),
    .pend_vec_o   (pend_vec_o),
    .pend_prio_o  (pend_prio_o),
    .act_prio_o   (act_prio_o),
    .preempt_o    (preempt_o),
    .can_take_o   (can_take_o)
);

// File: tb/tb_exc_prio_arb.sv
module tb_exc_prio_arb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_EXT    = 32;
    localparam int NVEC       = 16 + NUM_EXT;
    localparam int VW         = $clog2(NVEC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NVEC-1:0]   en, pend, act;
    logic [NVEC*8-1:0] prio;
    logic [2:0]        grp;
    logic              fmask, imask;
    logic [7:0]        base;

    logic [VW-1:0] pend_vec;
    logic [9:0]    pend_prio, act_prio;
    logic          preempt, can_take;

    exc_prio_arb #(.NUM_EXT(NUM_EXT)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .vec_en_i     (en),
        .vec_pend_i   (pend),
        .vec_act_i    (act),
        .prio_cfg_i   (prio),
        .grp_sel_i    (grp),
        .fault_mask_i (fmask),
        .irq_mask_i   (imask),
        .base_thr_i   (base),
        .pend_vec_o   (pend_vec),
        .pend_prio_o  (pend_prio),
        .act_prio_o   (act_prio),
        .preempt_o    (preempt),
        .can_take_o   (can_take)
    );

    typedef struct packed {
        logic [VW-1:0] vec;
        logic [9:0]    pp;
        logic [9:0]    ap;
        logic          pre;
        logic          take;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cmp(input string tag, input string what, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, actual, expected);
        end
    endtask

    task automatic cmp_all(input string tag, input exp_t e);
        cmp(tag, "pend_vec",  int'(pend_vec),  int'(e.vec));
        cmp(tag, "pend_prio", int'(pend_prio), int'(e.pp));
        cmp(tag, "act_prio",  int'(act_prio),  int'(e.ap));
        cmp(tag, "preempt",   int'(preempt),   int'(e.pre));
        cmp(tag, "can_take",  int'(can_take),  int'(e.take));
    endtask

    // monitor: one register stage, compare just after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                cmp_all(t, e);
            end
        end
    end

    // driver: inputs already set at this falling edge; queue the expectation
    task automatic expect_out(input int v, input logic [9:0] pp, input logic [9:0] ap,
                              input logic pre, input logic take, input string tag);
        exp_t e;
        e.vec  = VW'(v);
        e.pp   = pp;
        e.ap   = ap;
        e.pre  = pre;
        e.take = take;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic clear_all();
        en = '0; pend = '0; act = '0; prio = '0;
        grp = 3'd0; fmask = 1'b0; imask = 1'b0; base = 8'd0;
    endtask

    task automatic setp(input int v, input logic [7:0] val);
        prio[v*8 +: 8] = val;
    endtask

    task automatic cand(input int v, input logic [7:0] val);
        en[v] = 1'b1; pend[v] = 1'b1; setp(v, val);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t r;
        clear_all();
        rst_n = 1'b0;
        en = '1; pend = '1; act = '1;
        repeat (3) @(negedge clk);
        // R10: reset values while reset is held
        r.vec = '0; r.pp = 10'h100; r.ap = 10'h100; r.pre = 1'b0; r.take = 1'b0;
        cmp_all("R10", r);
        clear_all();
        rst_n = 1'b1;

        // R5: nothing pending
        expect_out(0, 10'h100, 10'h100, 0, 0, "R5");

        // R1: lowest priority value wins
        cand(20, 8'h40); cand(30, 8'h20);
        expect_out(30, 10'h020, 10'h100, 1, 1, "R1");

        // R2: equal priorities, lower number wins
        setp(20, 8'h20);
        expect_out(20, 10'h020, 10'h100, 1, 1, "R2");

        // R1: disabled vector is not a candidate
        setp(20, 8'h40); en[30] = 1'b0;
        expect_out(20, 10'h040, 10'h100, 1, 1, "R1");

        // R3: vector 0 never reported
        clear_all(); cand(0, 8'h00); cand(40, 8'h90);
        expect_out(40, 10'h090, 10'h100, 1, 1, "R3");
        pend[40] = 1'b0;
        expect_out(0, 10'h100, 10'h100, 0, 0, "R3");

        // R4: fixed negative priorities ignore programmed bytes
        clear_all(); cand(2, 8'hFF); cand(17, 8'h00);
        expect_out(2, 10'h3FE, 10'h100, 1, 1, "R4");
        cand(1, 8'h00); cand(3, 8'h00); setp(2, 8'h00);
        expect_out(1, 10'h3FD, 10'h100, 1, 1, "R4");

        // R6/R7: masked active equals pending -> no preempt, no take
        clear_all();
        act[25] = 1'b1; setp(25, 8'h47);
        act[26] = 1'b1; setp(26, 8'h60);
        cand(20, 8'h46);
        expect_out(20, 10'h046, 10'h046, 0, 0, "R6");

        // R6: wider subpriority field
        grp = 3'd3; setp(20, 8'h3F);
        expect_out(20, 10'h03F, 10'h040, 1, 1, "R6");

        // R7: CPU masks do not affect preemption
        clear_all(); imask = 1'b1; cand(20, 8'h10);
        expect_out(20, 10'h010, 10'h100, 1, 0, "R7");

        // R8: fault mask blocks hard fault, not NMI
        clear_all(); fmask = 1'b1; cand(3, 8'h00);
        expect_out(3, 10'h3FF, 10'h100, 1, 0, "R8");
        cand(2, 8'h00);
        expect_out(2, 10'h3FE, 10'h100, 1, 1, "R8");

        // R8: interrupt mask lets hard fault through
        clear_all(); imask = 1'b1; cand(3, 8'h00);
        expect_out(3, 10'h3FF, 10'h100, 1, 1, "R8");

        // R9: base threshold, equal priority blocked
        clear_all(); base = 8'h50; cand(20, 8'h50);
        expect_out(20, 10'h050, 10'h100, 1, 0, "R9");
        setp(20, 8'h4F);
        expect_out(20, 10'h04F, 10'h100, 1, 1, "R9");
        // R9: threshold masked to group priority
        grp = 3'd4; setp(20, 8'h45);
        expect_out(20, 10'h045, 10'h100, 1, 0, "R9");
        // R9: zero threshold has no effect
        grp = 3'd0; base = 8'h00; setp(20, 8'hFF);
        expect_out(20, 10'h0FF, 10'h100, 1, 1, "R9");

        // R6: negative active level masked
        clear_all(); act[1] = 1'b1; cand(2, 8'h00);
        expect_out(2, 10'h3FE, 10'h3FC, 0, 0, "R6");

        // R8: execution priority is min of base and active
        clear_all(); base = 8'h80; act[25] = 1'b1; setp(25, 8'h30); cand(20, 8'h40);
        expect_out(20, 10'h040, 10'h030, 0, 0, "R8");

        // R2: last external line vs first, equal priority
        clear_all(); cand(NVEC-1, 8'h10); cand(16, 8'h10);
        expect_out(16, 10'h010, 10'h100, 1, 1, "R2");

        @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule